// File: doc/BRIEF.md
# Shift-Accumulate Apnea Classifier

This block is a fixed-weight feedforward classifier that flags sleep apnea from two pre-processed fixed-point features: an ECG R-R interval and a blood-oxygen saturation value. Both features are signed 16-bit Q8.8 words. The network has four hidden layers of 8, 12, 6 and 4 neurons and one output neuron. Every weight is a signed power of two, so each product is an arithmetic right shift with an optional negation. No multiplier is used, and no memory macro is needed for the parameters.

A single shared shift-accumulate unit handles one weight per clock. A controller walks it neuron by neuron and layer by layer. Hidden results go to two 12-entry activation banks used in ping-pong fashion: one layer reads from one bank while it writes the other.

The controller has three states:
- **IDLE**: waits for `start_i`.
- **ACCUM**: adds one weighted input per cycle.
- **STORE**: saturates the sum, applies the activation, writes the result, then moves on.

Its transitions are:
- IDLE to ACCUM when a request is accepted.
- ACCUM to ACCUM while inputs remain.
- ACCUM to STORE after the last input of a neuron.
- STORE to ACCUM for the next neuron or layer.
- STORE to IDLE after the output neuron.

Top module: `sac_classifier`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o`, `done_o` and `class_o` are 0 and `score_o` is 0; a reset during a run abandons it.
- R2: When `start_i` is 1 in IDLE, the features on `rr_i` and `spo2_i` are captured at that clock edge and `busy_o` is 1 in the following cycle.
- R3: `done_o` rises exactly 243 cycles after the accepting edge, which is the sum over all layers of neurons × (fan-in + 1); `busy_o` falls at the same edge.
- R4: `done_o` is a single-cycle pulse.
- R5: A `start_i` while busy is ignored: the run in progress keeps its captured features and its timing, and no extra result is produced.
- R6: Layers are numbered l = 0..4, with 4 the output neuron. For input i of neuron j, let h = 13l + 7j + 5i + 3. The weight is 2^-(h mod 4), and it is negative when floor(h/4) mod 3 = 0. The product is the activation arithmetically shifted right by (h mod 4), negated if the weight is negative.
- R7: Each neuron starts from the bias 16·(((3l + 5j) mod 7) − 3) in Q8.8 units.
- R8: Sums are kept in 24 bits and saturated to [−32768, 32767] before activation; hidden neurons output 0 for a negative value and pass the value unchanged otherwise.
- R9: The output score is a piecewise-linear sigmoid of the saturated output sum x in Q8.8, with m = |x|. f = 128 + m/4 for m < 256, 160 + m/8 for m < 608, and 216 + m/32 for m < 1280, with each division truncating; otherwise f = 256. The score is f when x ≥ 0 and 256 − f when x < 0.
- R10: `class_o` is 1 (apnea) when the score is at least 0x0080 and 0 (normal) otherwise. `score_o` and `class_o` hold until the next result or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a classification of the presented features |
| rr_i | input | 16 | R-R interval feature, signed Q8.8 |
| spo2_i | input | 16 | Oxygen saturation feature, signed Q8.8 |
| busy_o | output | 1 | A classification is in progress |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| class_o | output | 1 | 1 = apnea, 0 = normal |
| score_o | output | 16 | Sigmoid output, Q8.8, range 0..0x0100 |

## Verification
- **`busy_o`** is due one cycle after the accepting edge.
- **`done_o`, `score_o` and `class_o`** all change together 243 edges after that edge.
- **`done_o` clearing** happens on the edge after it rises.

The bench drives inputs and samples outputs on falling clock edges. It counts rising edges from the accepting edge until `done_o` is seen, and compares that count with the latency it computes from the layer sizes. It then checks the score and class against an arithmetic model built from the weight, bias, saturation and sigmoid formulas, and checks one cycle later that `done_o` has cleared while the result holds.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int ACT_W    = 16;   // activation word, signed Q8.8
    localparam int ACC_W    = 24;   // accumulator width
    localparam int FRAC     = 8;    // fractional bits
    localparam int N_FEAT   = 2;    // network inputs
    localparam int N_LAYERS = 5;    // four hidden layers plus the output neuron
    localparam int MAX_N    = 12;   // widest layer
    localparam int SH_W     = 2;    // weight shift amount width
    localparam int IDX_W    = $clog2(MAX_N);
    localparam int LAY_W    = $clog2(N_LAYERS);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_STORE = 2'd2
    } state_t;

    typedef struct packed {
        logic            neg;
        logic [SH_W-1:0] sh;
    } wcode_t;

    function automatic int layer_size(input int l);
        case (l)
            0:       return 8;
            1:       return 12;
            2:       return 6;
            3:       return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int fan_in(input int l);
        return (l == 0) ? N_FEAT : layer_size(l - 1);
    endfunction

    function automatic int total_cycles();
        int t;
        t = 0;
        for (int l = 0; l < N_LAYERS; l++) begin
            t += layer_size(l) * (fan_in(l) + 1);
        end
        return t;
    endfunction

    localparam int LATENCY = total_cycles();

    // Power-of-two weight for input i of neuron j in layer l
    function automatic wcode_t weight_code(input int l, input int j, input int i);
        int h;
        wcode_t c;
        h     = 13 * l + 7 * j + 5 * i + 3;
        c.neg = ((h / 4) % 3) == 0;
        c.sh  = SH_W'(h % 4);
        return c;
    endfunction

    function automatic logic signed [ACT_W-1:0] bias_of(input int l, input int j);
        return ACT_W'((((3 * l + 5 * j) % 7) - 3) * 16);
    endfunction

endpackage

// File: rtl/sac_ctrl.sv
module sac_ctrl
    import sac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [LAY_W-1:0] layer_o,
    output logic [IDX_W-1:0] neuron_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             accept_o,
    output logic             acc_en_o,
    output logic             first_o,
    output logic             store_o,
    output logic             final_o
);

    state_t           state_q, state_d;
    logic [LAY_W-1:0] layer_q, layer_d;
    logic [IDX_W-1:0] neuron_q, neuron_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             last_idx, last_neuron, last_layer;

    assign last_idx    = (int'(idx_q) == fan_in(int'(layer_q)) - 1);
    assign last_neuron = (int'(neuron_q) == layer_size(int'(layer_q)) - 1);
    assign last_layer  = (int'(layer_q) == N_LAYERS - 1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            layer_q  <= '0;
            neuron_q <= '0;
            idx_q    <= '0;
        end else begin
            state_q  <= state_d;
            layer_q  <= layer_d;
            neuron_q <= neuron_d;
            idx_q    <= idx_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        layer_d  = layer_q;
        neuron_d = neuron_q;
        idx_d    = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d  = S_ACCUM;
                    layer_d  = '0;
                    neuron_d = '0;
                    idx_d    = '0;
                end
            end
            S_ACCUM: begin
                if (last_idx) begin
                    state_d = S_STORE;
                end else begin
                    idx_d = idx_q + IDX_W'(1);
                end
            end
            S_STORE: begin
                idx_d   = '0;
                state_d = S_ACCUM;
                if (last_neuron) begin
                    neuron_d = '0;
                    if (last_layer) begin
                        state_d = S_IDLE;
                    end else begin
                        layer_d = layer_q + LAY_W'(1);
                    end
                end else begin
                    neuron_d = neuron_q + IDX_W'(1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        layer_o  = layer_q;
        neuron_o = neuron_q;
        idx_o    = idx_q;
        busy_o   = (state_q != S_IDLE);
        accept_o = (state_q == S_IDLE) && start_i;
        acc_en_o = (state_q == S_ACCUM);
        first_o  = (idx_q == '0);
        store_o  = (state_q == S_STORE);
        final_o  = (state_q == S_STORE) && last_layer && last_neuron;
    end

    // R2: an accepted request moves the controller to accumulation
    a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start_i) |=> (state_q == S_ACCUM));

    // R5: a run in progress ends only after the output neuron
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && !final_o) |=> (state_q != S_IDLE));

endmodule

// File: rtl/sac_mac.sv
module sac_mac
    import sac_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int CW = ACC_W
) (
    input  logic                 clk,
    input  logic                 en_i,
    input  logic                 first_i,
    input  logic signed [AW-1:0] op_i,
    input  wcode_t               code_i,
    input  logic signed [AW-1:0] bias_i,
    output logic signed [CW-1:0] acc_o
);

    localparam int EXT = CW - AW;

    logic signed [AW-1:0] shifted;
    logic signed [CW-1:0] term_ext, term, bias_ext, base;
    logic signed [CW-1:0] acc_q;

    always_comb begin
        shifted  = op_i >>> code_i.sh;
        term_ext = {{EXT{shifted[AW-1]}}, shifted};
        term     = code_i.neg ? -term_ext : term_ext;
        bias_ext = {{EXT{bias_i[AW-1]}}, bias_i};
        base     = first_i ? bias_ext : acc_q;
    end

    always_ff @(posedge clk) begin
        if (en_i) begin
            acc_q <= base + term;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/sac_act.sv
module sac_act
    import sac_pkg::*;
#(
    parameter int AW = ACT_W,
    parameter int CW = ACC_W,
    parameter int FB = FRAC
) (
    input  logic signed [CW-1:0] acc_i,
    output logic signed [AW-1:0] relu_o,
    output logic        [AW-1:0] sig_o
);

    localparam int ONE  = 1 << FB;
    localparam int HALF = ONE / 2;
    localparam int BRK2 = (19 * ONE) / 8;
    localparam int BRK3 = 5 * ONE;
    localparam int OFF2 = (5 * ONE) / 8;
    localparam int OFF3 = (27 * ONE) / 32;
    localparam logic signed [CW-1:0] SAT_HI = CW'((2 ** (AW - 1)) - 1);
    localparam logic signed [CW-1:0] SAT_LO = -SAT_HI - CW'(1);

    logic signed [AW-1:0] sat_v;
    logic signed [AW:0]   wide;
    logic        [AW:0]   mag, f, score;

    always_comb begin
        if (acc_i > SAT_HI) begin
            sat_v = SAT_HI[AW-1:0];
        end else if (acc_i < SAT_LO) begin
            sat_v = SAT_LO[AW-1:0];
        end else begin
            sat_v = acc_i[AW-1:0];
        end
        relu_o = sat_v[AW-1] ? '0 : sat_v;

        wide = {sat_v[AW-1], sat_v};
        mag  = $unsigned(wide[AW] ? -wide : wide);
        if (mag < (AW+1)'(ONE)) begin
            f = (AW+1)'(HALF) + (mag >> 2);
        end else if (mag < (AW+1)'(BRK2)) begin
            f = (AW+1)'(OFF2) + (mag >> 3);
        end else if (mag < (AW+1)'(BRK3)) begin
            f = (AW+1)'(OFF3) + (mag >> 5);
        end else begin
            f = (AW+1)'(ONE);
        end
        score = wide[AW] ? (AW+1)'(ONE) - f : f;
        sig_o = score[AW-1:0];
    end

endmodule

// File: rtl/sac_classifier.sv
module sac_classifier
    import sac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [15:0] rr_i,
    input  logic [15:0] spo2_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        class_o,
    output logic [15:0] score_o
);

    localparam int BANKS = 2;
    localparam logic [ACT_W-1:0] DECIDE = ACT_W'(1 << (FRAC - 1));

    logic [LAY_W-1:0]         layer_w;
    logic [IDX_W-1:0]         neuron_w, idx_w;
    logic                     accept, acc_en, first, store, fin;
    logic signed [ACT_W-1:0]  operand, bias, relu;
    logic        [ACT_W-1:0]  sig;
    logic signed [ACC_W-1:0]  acc;
    wcode_t                   code;
    logic signed [ACT_W-1:0]  bank_q [BANKS][MAX_N];

    sac_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .layer_o  (layer_w),
        .neuron_o (neuron_w),
        .idx_o    (idx_w),
        .busy_o   (busy_o),
        .accept_o (accept),
        .acc_en_o (acc_en),
        .first_o  (first),
        .store_o  (store),
        .final_o  (fin)
    );

    // Layer l reads bank l mod 2 and writes the other one
    always_comb begin
        operand = bank_q[layer_w[0]][idx_w];
        code    = weight_code(int'(layer_w), int'(neuron_w), int'(idx_w));
        bias    = bias_of(int'(layer_w), int'(neuron_w));
    end

    sac_mac #(.AW(ACT_W), .CW(ACC_W)) u_mac (
        .clk     (clk),
        .en_i    (acc_en),
        .first_i (first),
        .op_i    (operand),
        .code_i  (code),
        .bias_i  (bias),
        .acc_o   (acc)
    );

    sac_act #(.AW(ACT_W), .CW(ACC_W), .FB(FRAC)) u_act (
        .acc_i  (acc),
        .relu_o (relu),
        .sig_o  (sig)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            bank_q[0][0] <= rr_i;
            bank_q[0][1] <= spo2_i;
        end else if (store && !fin) begin
            bank_q[~layer_w[0]][neuron_w] <= relu;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            class_o <= 1'b0;
            score_o <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                score_o <= sig;
                class_o <= (sig >= DECIDE);
            end
        end
    end

    // Cycle counter used only by the latency assertion
    int lat_q;
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            lat_q <= 0;
        end else if (busy_o) begin
            lat_q <= lat_q + 1;
        end
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_q == LATENCY));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_relu_nonneg: assert property (@(posedge clk) disable iff (rst)
        (store && !fin) |-> !relu[ACT_W-1]);

    a_r9_score_range: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (score_o <= 16'h0100));

endmodule

// File: tb/test_sac_classifier.sv
module test_sac_classifier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] rr_i = '0;
    logic [15:0] spo2_i = '0;
    logic        busy_o, done_o, class_o;
    logic [15:0] score_o;

    int n_chk  = 0;
    int n_fail = 0;
    int lat_exp;

    always #2 clk = ~clk;

    sac_classifier i_sac_classifier (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .rr_i    (rr_i),
        .spo2_i  (spo2_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .class_o (class_o),
        .score_o (score_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sz(input int l);
        case (l)
            0: return 8;  1: return 12;  2: return 6;  3: return 4;
            default: return 1;
        endcase
    endfunction

    // Arithmetic model: R6 weights, R7 biases, R8 saturation/ReLU, R9 sigmoid
    function automatic void model(input int rr, input int sp, output int score, output int cls);
        int a[12];
        int nx[12];
        int fin, acc, p, h, x, m, f;
        a[0] = rr; a[1] = sp; fin = 2; x = 0;
        for (int l = 0; l < 5; l++) begin
            for (int j = 0; j < sz(l); j++) begin
                acc = 16 * (((3 * l + 5 * j) % 7) - 3);
                for (int i = 0; i < fin; i++) begin
                    h = 13 * l + 7 * j + 5 * i + 3;
                    p = a[i] >>> (h % 4);
                    if (((h / 4) % 3) == 0) p = -p;
                    acc += p;
                end
                if (acc > 32767) acc = 32767;
                if (acc < -32768) acc = -32768;
                if (l < 4) nx[j] = (acc < 0) ? 0 : acc;
                else x = acc;
            end
            for (int j = 0; j < 12; j++) a[j] = nx[j];
            fin = sz(l);
        end
        m = (x < 0) ? -x : x;
        if (m < 256)       f = 128 + m / 4;
        else if (m < 608)  f = 160 + m / 8;
        else if (m < 1280) f = 216 + m / 32;
        else               f = 256;
        score = (x < 0) ? 256 - f : f;
        cls   = (score >= 128) ? 1 : 0;
    endfunction

    // Start a run, optionally poke a second start while busy, and check the result
    task automatic run(input int rr, input int sp, input int poke_at, input int rr2, input int sp2);
        int n, es, ec;
        model(rr, sp, es, ec);
        @(negedge clk);
        rr_i = 16'(rr); spo2_i = 16'(sp); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after accept", int'(busy_o), 1);
        n = 0;
        while (!done_o && n < 1000) begin
            if (n == poke_at) begin
                rr_i = 16'(rr2); spo2_i = 16'(sp2); start_i = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        check(n == lat_exp, "R3 latency", n, lat_exp);
        check(busy_o == 1'b0, "R3 busy falls with done", int'(busy_o), 0);
        check(int'(score_o) == es, "R6 R7 R8 R9 score", int'(score_o), es);
        check(int'(class_o) == ec, "R10 class", int'(class_o), ec);
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R4 done single cycle", int'(done_o), 0);
        check(int'(score_o) == es && int'(class_o) == ec, "R10 result holds", int'(score_o), es);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        lat_exp = 0;
        for (int l = 0; l < 5; l++) lat_exp += sz(l) * (((l == 0) ? 2 : sz(l - 1)) + 1);

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o && !class_o && score_o == 0, "R1 during reset", int'(score_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !class_o && score_o == 0, "R1 after reset", int'(busy_o), 0);

        // Coarse sweep over the full signed range, including extremes (R8)
        for (int a = 0; a < 12; a++)
            for (int b = 0; b < 12; b++)
                run(-32768 + a * 5957, -32768 + b * 5957, -1, 0, 0);

        // Fine sweep over physiological-looking values
        for (int a = 0; a < 12; a++)
            for (int b = 0; b < 12; b++)
                run(64 + 48 * a, 160 + 20 * b - 120, -1, 0, 0);

        // R5: a start while busy is ignored
        run(300, 230, 40, -20000, 25000);
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < lat_exp + 20; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (done_o || busy_o) seen = 1'b1;
            end
            check(!seen, "R5 no extra run", int'(seen), 0);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        rr_i = 16'(500); spo2_i = 16'(-700); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy_o && !done_o && !class_o && score_o == 0, "R1 mid-run reset", int'(busy_o), 0);
        run(500, -700, -1, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule